// File: doc/BRIEF.md
# Reloading Down-Counter Timer Channel

A single timer channel whose counter steps down by one on each prescaled tick of the peripheral clock. When the counter steps down from zero it is loaded again from a reload constant. A sticky underflow flag is set at that point and, if enabled, drives a level interrupt. Software reaches the channel through four word-indexed registers: reload constant, live counter, control word and an optional capture register. An external start input decides whether the channel counts.

The control word holds a prescaler select, a clock-edge field and a capture-enable field (both of these are only stored and checked), the interrupt enable and the underflow flag. A write that carries a reserved bit or an invalid code leaves that field unchanged and sets a sticky configuration-error output. The valid fields of the same write still take effect.

The channel runs a two-state machine. In CH_STOPPED the prescaler and counter hold. The transition START (start input high) moves it to CH_COUNTING. In CH_COUNTING the prescaler advances every clock, and the transition HALT (start input low) returns it to CH_STOPPED. Each transition takes effect at the clock edge that samples the start input.

Top module: `dcnt_timer_chan`

## Requirements
- R1: After reset the reload register (index 0) and the counter (index 1) read 0xFFFFFFFF. The control word (index 2) and the capture register (index 3) read 0. The channel is stopped, and irq and cfg_err are 0.
- R2: A write to index 0 stores the reload constant, and a later read returns the stored value.
- R3: While counting, the prescaler ticks every 4^(S+1) clocks for select S in bits [2:0] = 0..4. The first tick comes that many clocks after the edge that enters CH_COUNTING. The counter drops by one on each tick.
- R4: While run_en is low the counter and the prescaler phase hold. When run_en rises again, counting resumes from the held value.
- R5: A tick that finds the counter at 0 loads the reload constant and sets the underflow flag.
- R6: irq is 1 exactly when the underflow flag is 1 and the interrupt enable (control bit 5) is 1.
- R7: A control write with bit 8 = 0 clears the flag, and one with bit 8 = 1 leaves it unchanged. An underflow in the same cycle as a clearing write leaves the flag set.
- R8: A control read returns {bit 8 flag, [7:6] capture enable, 5 interrupt enable, [4:3] edge, [2:0] select}. Bit 9 and bits [31:10] read 0.
- R9: A control write with select 5 (or 6/7 without the external-clock feature), a nonzero edge code without that feature, capture-enable code 1, bit 9 set without capture, or any bit in [31:10] set leaves the offending field unchanged and sets cfg_err. cfg_err stays set until reset.
- R10: A counter write is visible in the next cycle and restarts the prescaler phase. It takes priority over a tick in the same cycle.
- R11: With the capture feature, index 3 is a read/write register. Without it, index 3 reads 0, and a write to it is ignored and sets cfg_err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_idx | input | 2 | Word index of the register accessed |
| wdata | input | W | Write data |
| run_en | input | 1 | Start enable for counting |
| rdata | output | W | Read data of the register at reg_idx |
| irq | output | 1 | Level underflow interrupt |
| cfg_err | output | 1 | Sticky invalid-configuration indicator |

## Verification
The hardest case to produce from the ports is an underflow that lands on the same edge as a control write that clears the flag. The stimulus gets there by writing the counter to zero, which restarts the prescaler phase. It then waits the exact number of clocks for the select in use and issues the clearing write on the tick edge. Random traffic keeps small reload and counter values, a mostly fast prescaler, and toggles of the start input. This makes reloads, freezes and resumes frequent. A cycle-level model built from the requirements checks every register each step.

// File: rtl/dcnt_pkg.sv
package dcnt_pkg;
    localparam int SEL_W       = 3;
    localparam int MAX_DIV_SEL = 4;
    localparam int PRE_W       = 2 * MAX_DIV_SEL + 2;

    localparam logic [1:0] IDX_RELOAD = 2'd0;
    localparam logic [1:0] IDX_COUNT  = 2'd1;
    localparam logic [1:0] IDX_CTRL   = 2'd2;
    localparam logic [1:0] IDX_CAPT   = 2'd3;

    typedef enum logic {
        CH_STOPPED  = 1'b0,
        CH_COUNTING = 1'b1
    } ch_state_e;

    typedef struct packed {
        logic [1:0]       cap_en;
        logic             uf_ie;
        logic [1:0]       edge_sel;
        logic [SEL_W-1:0] div_sel;
    } ctrl_t;

    function automatic logic sel_ok(input logic [SEL_W-1:0] s, input logic ext);
        return (s <= SEL_W'(MAX_DIV_SEL)) || (ext && (s >= SEL_W'(6)));
    endfunction
endpackage

// File: rtl/dcnt_prescaler.sv
module dcnt_prescaler
    import dcnt_pkg::*;
#(
    parameter int PW = PRE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             restart,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PW-1:0] pc;
    logic [PW-1:0] lim;
    logic          internal;

    always_comb begin
        internal = (sel <= SEL_W'(MAX_DIV_SEL));
        lim      = (PW'(4) << {sel, 1'b0}) - PW'(1);
        tick     = en && internal && (pc >= lim);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)              pc <= '0;
        else if (restart)        pc <= '0;
        else if (en && internal) pc <= tick ? '0 : pc + PW'(1);
    end

    // R3: the smallest divide is 4, so two ticks are never adjacent
    assert_tick_spacing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/dcnt_core.sv
module dcnt_core
    import dcnt_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_en,
    input  logic         tick,
    input  logic         cnt_wr,
    input  logic [W-1:0] cnt_wdata,
    input  logic [W-1:0] reload,
    input  logic         flag_clr,
    output logic [W-1:0] cnt,
    output logic         flag,
    output logic         running
);
    ch_state_e state, state_nx;
    logic      wrap;

    always_comb begin
        state_nx = state;
        unique case (state)
            CH_STOPPED:  if (run_en)  state_nx = CH_COUNTING;
            CH_COUNTING: if (!run_en) state_nx = CH_STOPPED;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= CH_STOPPED;
        else        state <= state_nx;
    end

    always_comb begin
        running = (state == CH_COUNTING);
        wrap    = tick && (cnt == '0) && !cnt_wr;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '1;
            flag <= 1'b0;
        end else begin
            if (cnt_wr)    cnt <= cnt_wdata;
            else if (tick) cnt <= (cnt == '0) ? reload : cnt - W'(1);
            if (wrap)          flag <= 1'b1;
            else if (flag_clr) flag <= 1'b0;
        end
    end

    assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt == '0 && !cnt_wr) |=> (cnt == $past(reload) && flag));
    assert_decrement_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt != '0 && !cnt_wr) |=> (cnt == $past(cnt) - W'(1)));
    assert_hold_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_wr) |=> $stable(cnt));
    assert_cnt_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> (cnt == $past(cnt_wdata)));
    assert_flag_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> $past(tick && cnt == '0));
    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr && !(tick && cnt == '0 && !cnt_wr)) |=> !flag);
endmodule

// File: rtl/dcnt_regs.sv
module dcnt_regs
    import dcnt_pkg::*;
#(
    parameter int W           = 32,
    parameter int HAS_CAPTURE = 1,
    parameter int HAS_EXTCLK  = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   idx,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] cnt,
    input  logic         flag,
    output logic [W-1:0] reload,
    output ctrl_t        ctrl,
    output logic [W-1:0] rdata,
    output logic         cfg_err,
    output logic         cnt_wr,
    output logic         flag_clr
);
    localparam logic EXT = (HAS_EXTCLK != 0);
    localparam logic CAP = (HAS_CAPTURE != 0);

    logic         wr_rel, wr_ctrl, wr_capt, bad, capt_bad;
    ctrl_t        nctrl;
    logic [W-1:0] capr;

    always_comb begin
        wr_rel   = wr_en && (idx == IDX_RELOAD);
        cnt_wr   = wr_en && (idx == IDX_COUNT);
        wr_ctrl  = wr_en && (idx == IDX_CTRL);
        wr_capt  = wr_en && (idx == IDX_CAPT);
        flag_clr = wr_ctrl && !wdata[8];
    end

    always_comb begin
        nctrl = ctrl;
        bad   = 1'b0;
        if (sel_ok(wdata[2:0], EXT)) nctrl.div_sel = wdata[2:0];
        else bad = 1'b1;
        if (wdata[4:3] == 2'b00 || EXT) nctrl.edge_sel = wdata[4:3];
        else bad = 1'b1;
        nctrl.uf_ie = wdata[5];
        if (wdata[7:6] == 2'b00 || (CAP && wdata[7:6] != 2'b01)) nctrl.cap_en = wdata[7:6];
        else bad = 1'b1;
        if (wdata[9] && !CAP) bad = 1'b1;
        if (|wdata[W-1:10]) bad = 1'b1;
    end

    generate
        if (HAS_CAPTURE != 0) begin : g_cap
            always_ff @(posedge clk) begin
                if (!rst_n)       capr <= '0;
                else if (wr_capt) capr <= wdata;
            end
            assign capt_bad = 1'b0;
        end else begin : g_nocap
            assign capr     = '0;
            assign capt_bad = wr_capt;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reload  <= '1;
            ctrl    <= '0;
            cfg_err <= 1'b0;
        end else begin
            if (wr_rel)  reload <= wdata;
            if (wr_ctrl) ctrl   <= nctrl;
            if ((wr_ctrl && bad) || capt_bad) cfg_err <= 1'b1;
        end
    end

    always_comb begin
        unique case (idx)
            IDX_RELOAD: rdata = reload;
            IDX_COUNT:  rdata = cnt;
            IDX_CTRL:   rdata = W'({flag, ctrl});
            IDX_CAPT:   rdata = capr;
        endcase
    end

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);
    assert_bad_sel_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && wdata[2:0] == 3'd5) |=> ($stable(ctrl.div_sel) && cfg_err));
endmodule

// File: rtl/dcnt_timer_chan.sv
module dcnt_timer_chan
    import dcnt_pkg::*;
#(
    parameter int W           = 32,
    parameter int HAS_CAPTURE = 1,
    parameter int HAS_EXTCLK  = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [1:0]   reg_idx,
    input  logic [W-1:0] wdata,
    input  logic         run_en,
    output logic [W-1:0] rdata,
    output logic         irq,
    output logic         cfg_err
);
    logic [W-1:0] reload, cnt;
    ctrl_t        ctrl;
    logic         cnt_wr, flag_clr, flag, running, tick;

    dcnt_regs #(.W(W), .HAS_CAPTURE(HAS_CAPTURE), .HAS_EXTCLK(HAS_EXTCLK)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(reg_idx), .wdata(wdata),
        .cnt(cnt), .flag(flag), .reload(reload), .ctrl(ctrl), .rdata(rdata),
        .cfg_err(cfg_err), .cnt_wr(cnt_wr), .flag_clr(flag_clr)
    );

    dcnt_prescaler #(.PW(PRE_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(running), .restart(cnt_wr),
        .sel(ctrl.div_sel), .tick(tick)
    );

    dcnt_core #(.W(W)) u_core (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick), .cnt_wr(cnt_wr),
        .cnt_wdata(wdata), .reload(reload), .flag_clr(flag_clr), .cnt(cnt),
        .flag(flag), .running(running)
    );

    always_comb irq = flag && ctrl.uf_ie;

    // R4: no tick can reach the counter while the channel is stopped
    assert_no_tick_stopped_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> !tick);
endmodule

// File: tb/tb_dcnt_timer_chan.sv
`timescale 1ns/100ps
module tb_dcnt_timer_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  idx = 2'd0;
    logic [31:0] wdata = '0;
    logic        run_en = 1'b0;
    logic [31:0] rdata;
    logic        irq, cfg_err;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #5 clk = ~clk;

    dcnt_timer_chan dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_idx(idx), .wdata(wdata),
        .run_en(run_en), .rdata(rdata), .irq(irq), .cfg_err(cfg_err)
    );

    // reference model built from the requirements
    logic [31:0] m_rel, m_cnt, m_capr;
    logic [2:0]  m_sel;
    logic [1:0]  m_edge, m_cap;
    logic        m_ie, m_flag, m_err, m_run;
    int          m_pc, m_div;
    bit          m_tk, m_uf, m_wc, m_bad;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_rel = '1; m_cnt = '1; m_capr = '0; m_sel = 0; m_edge = 0; m_cap = 0;
            m_ie = 0; m_flag = 0; m_err = 0; m_run = 0; m_pc = 0;
        end else begin
            m_div = 4 << (2 * m_sel);
            m_tk  = m_run && (m_sel <= 4) && (m_pc >= m_div - 1);
            m_wc  = wr_en && idx == 2'd1;
            m_uf  = m_tk && m_cnt == 0 && !m_wc;
            if (m_wc) m_pc = 0;
            else if (m_run && m_sel <= 4) m_pc = m_tk ? 0 : m_pc + 1;
            if (m_wc) m_cnt = wdata;
            else if (m_tk) m_cnt = (m_cnt == 0) ? m_rel : m_cnt - 1;
            if (m_uf) m_flag = 1;
            else if (wr_en && idx == 2'd2 && !wdata[8]) m_flag = 0;
            if (wr_en && idx == 2'd0) m_rel = wdata;
            if (wr_en && idx == 2'd3) m_capr = wdata;
            if (wr_en && idx == 2'd2) begin
                m_bad = 0;
                if (wdata[2:0] <= 4) m_sel = wdata[2:0]; else m_bad = 1;
                if (wdata[4:3] == 0) m_edge = 0; else m_bad = 1;
                m_ie = wdata[5];
                if (wdata[7:6] != 2'b01) m_cap = wdata[7:6]; else m_bad = 1;
                if (wdata[31:10] != 0) m_bad = 1;
                if (m_bad) m_err = 1;
            end
            m_run = run_en;
        end
    end

    function automatic logic [31:0] mread(input logic [1:0] i);
        case (i)
            2'd0: return m_rel;
            2'd1: return m_cnt;
            2'd2: return {22'b0, m_flag, m_cap, m_ie, m_edge, m_sel};
            default: return m_capr;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] i, output logic [31:0] v);
        idx = i; #1; v = rdata;
    endtask

    task automatic wr(input logic [1:0] i, input logic [31:0] v);
        wr_en = 1; idx = i; wdata = v;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic waitn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_all();
        logic [31:0] v;
        rd(2'd0, v); chk("R2 reload", v, mread(2'd0));
        rd(2'd1, v); chk("R3 counter", v, mread(2'd1));
        rd(2'd2, v); chk("R8 control", v, mread(2'd2));
        rd(2'd3, v); chk("R11 capture", v, mread(2'd3));
        chk("R6 irq", {31'b0, irq}, {31'b0, m_flag & m_ie});
        chk("R9 cfg_err", {31'b0, cfg_err}, {31'b0, m_err});
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [31:0] cw;
        int r;
        void'($urandom(32'd1234));
        waitn(3);
        rst_n = 1;
        waitn(1);
        // R1 reset state
        rd(2'd0, v); chk("R1 reload", v, 32'hFFFF_FFFF);
        rd(2'd1, v); chk("R1 counter", v, 32'hFFFF_FFFF);
        rd(2'd2, v); chk("R1 control", v, 32'h0);
        rd(2'd3, v); chk("R1 capture", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);
        chk("R1 cfg_err", {31'b0, cfg_err}, 32'h0);
        waitn(1);
        // R2, R11 storage
        wr(2'd0, 32'd5);
        wr(2'd3, 32'h1234_5678);
        rd(2'd0, v); chk("R2 reload readback", v, 32'd5);
        rd(2'd3, v); chk("R11 capture readback", v, 32'h1234_5678);
        waitn(1);
        // R10 counter write visible next cycle
        wr(2'd1, 32'd10);
        rd(2'd1, v); chk("R10 counter write", v, 32'd10);
        waitn(1);
        wr(2'd2, 32'h20);
        // R3 divide by 4: three ticks in 13 edges after start
        run_en = 1;
        waitn(13);
        rd(2'd1, v); chk("R3 divide-by-4 count", v, 32'd7);
        // R4 freeze
        run_en = 0;
        waitn(20);
        rd(2'd1, v); chk("R4 frozen count", v, 32'd7);
        check_all();
        waitn(1);
        // R5 underflow from zero
        wr(2'd1, 32'd0);
        run_en = 1;
        waitn(5);
        rd(2'd1, v); chk("R5 reload on underflow", v, 32'd5);
        rd(2'd2, v); chk("R5 flag set", {31'b0, v[8]}, 32'd1);
        chk("R6 irq with enable", {31'b0, irq}, 32'd1);
        // R6 / R7 enable off, flag kept
        wr(2'd2, 32'h100);
        chk("R6 irq masked", {31'b0, irq}, 32'd0);
        rd(2'd2, v); chk("R7 flag kept by bit8=1", v, 32'h100);
        wr(2'd2, 32'h120);
        chk("R6 irq unmasked", {31'b0, irq}, 32'd1);
        wr(2'd2, 32'h020);
        rd(2'd2, v); chk("R7 flag cleared", v, 32'h020);
        chk("R7 irq after clear", {31'b0, irq}, 32'd0);
        // R9 invalid select
        wr(2'd2, 32'h025);
        rd(2'd2, v); chk("R9 select kept", v, 32'h020);
        chk("R9 cfg_err set", {31'b0, cfg_err}, 32'd1);
        // R10 phase restart
        wr(2'd1, 32'd2);
        waitn(4);
        rd(2'd1, v); chk("R10 phase restart", v, 32'd1);
        // R7 underflow beats same-cycle clear
        wr(2'd1, 32'd0);
        waitn(3);
        wr(2'd2, 32'h020);
        rd(2'd2, v); chk("R7 underflow wins over clear", {31'b0, v[8]}, 32'd1);
        check_all();
        // random phase
        for (int it = 0; it < 4000; it++) begin
            r = $urandom % 8;
            case (r)
                0: wr(2'd0, $urandom % 12);
                1: wr(2'd1, $urandom % 24);
                2: begin
                    cw = '0;
                    cw[2:0] = (($urandom % 4) == 0) ? 3'($urandom % 8) : 3'($urandom % 2);
                    cw[4:3] = (($urandom % 8) == 0) ? 2'($urandom % 4) : 2'd0;
                    cw[5]   = 1'($urandom % 2);
                    cw[7:6] = 2'($urandom % 4);
                    cw[8]   = 1'($urandom % 2);
                    cw[9]   = 1'($urandom % 2);
                    if (($urandom % 10) == 0) cw = cw | (32'd1 << (10 + ($urandom % 22)));
                    wr(2'd2, cw);
                end
                3: wr(2'd3, $urandom);
                4: begin run_en = ~run_en; waitn(1); end
                default: waitn(1 + $urandom % 6);
            endcase
            check_all();
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule